// File: doc/BRIEF.md
# Shared Debounce Timer Selector

This block cleans up a bank of slow input lines, such as buttons, straps or presence detects, with a small pool of debounce timers that all pins share. Three period registers each hold a stability window counted in clock cycles. Every pin carries a 2-bit timer code that chooses one of the three windows, or no filtering at all. A filtered pin moves its output to a new level only after the raw input has stayed at that level for the whole window. A pin with code zero tracks its input after one register stage.

The timer code of a pin is split across two select words. One word holds the upper code bit of every pin and the other holds the lower code bit. Bit n of each word belongs to pin n. Software therefore changes a pin's timer by rewriting one bit in one or both words. Any bus master may write the configuration at any time. Changing a pin's code restarts its stability count but leaves its present output level alone.

The register port is a plain single-cycle write strobe with a combinational read. The raw inputs are expected to be synchronous to `clk` already.

Top module: `debounce_pool`

## Requirements
- R1: After reset, every select word and period register reads 0 and every `pin_db` bit is 0.
- R2: Byte address 0x00 holds the upper code bit of each pin and 0x04 holds the lower code bit, each at bit position n for pin n. Addresses 0x10, 0x14 and 0x18 hold the periods of timers 1, 2 and 3. A write takes effect at the clock edge where `reg_wr` is high. Reads are combinational and return the stored bits zero-extended: the low NUM_PINS bits of a select word, or the low CNT_W bits of a period.
- R3: A write to any other address changes no register, and a read of any other address returns 0.
- R4: A pin whose code {upper bit, lower bit} is 0 drives `pin_db` equal to its raw input as sampled at the previous clock edge.
- R5: Codes 1, 2 and 3 select timer 1, 2 and 3 respectively.
- R6: With a selected period P of 1 or more, `pin_db` takes a new raw level at the P-th consecutive clock edge that samples the raw input at that level, and at no earlier edge.
- R7: A raw excursion that lasts fewer than P sampling edges leaves `pin_db` unchanged, and the count starts over once the input returns.
- R8: A selected timer whose period is 0 behaves like code 0 for every pin that selects it (one-edge tracking).
- R9: At the first edge that sees a changed nonzero code, the pin's count restarts and its output holds its level. A new level then needs P further edges.
- R10: Pins count independently. Pins that select different timers settle after their own periods even when their inputs change together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| pin_raw | input | NUM_PINS | Raw input levels, synchronous to `clk` |
| pin_db | output | NUM_PINS | Filtered levels |

## Verification
A register write becomes visible at the edge that captures it, so reads are sampled 1 ns after the next falling edge. A pin with code 0 or a zero period shows its new level one edge after the raw change. A filtered pin shows its new level P edges after the raw change. After a code change, the restart takes effect at the edge after the write, and the level is due P edges later. The bench changes inputs on the falling edge and counts rising edges one at a time, sampling after each falling edge. Each latency is therefore measured as an exact edge count and compared with the count worked out from the requirements.

// File: rtl/debounce_pool_pkg.sv
package debounce_pool_pkg;
  localparam int CODE_W     = 2;
  localparam int NUM_TIMERS = 3;
  localparam int ADDR_SEL_HI  = 'h00;
  localparam int ADDR_SEL_LO  = 'h04;
  localparam int ADDR_PER_BASE = 'h10;
  localparam int ADDR_PER_STEP = 4;

  typedef enum logic [CODE_W-1:0] {
    CODE_OFF = 2'd0,
    CODE_T1  = 2'd1,
    CODE_T2  = 2'd2,
    CODE_T3  = 2'd3
  } tmr_code_e;
endpackage

// File: rtl/debounce_pool_regs.sv
module debounce_pool_regs
  import debounce_pool_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  output logic [NUM_PINS-1:0]         sel_hi,
  output logic [NUM_PINS-1:0]         sel_lo,
  output logic [NUM_TIMERS*CNT_W-1:0] period_flat
);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(ADDR_SEL_HI);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(ADDR_SEL_LO);

  logic                  hi_hit, lo_hit, mapped;
  logic [NUM_TIMERS-1:0] per_hit;
  logic [CNT_W-1:0]      period_q [NUM_TIMERS];
  logic                  unused_wdata_bits;

  assign unused_wdata_bits = ^reg_wdata;
  assign hi_hit = (reg_addr == A_HI);
  assign lo_hit = (reg_addr == A_LO);
  assign mapped = hi_hit | lo_hit | (|per_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_hi <= '0;
      sel_lo <= '0;
    end else if (reg_wr) begin
      if (hi_hit) sel_hi <= reg_wdata[NUM_PINS-1:0];
      if (lo_hit) sel_lo <= reg_wdata[NUM_PINS-1:0];
    end
  end

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
    localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(ADDR_PER_BASE + ADDR_PER_STEP * t);
    assign per_hit[t] = (reg_addr == A_PER);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   period_q[t] <= '0;
      else if (reg_wr && per_hit[t]) period_q[t] <= reg_wdata[CNT_W-1:0];
    end

    assign period_flat[t*CNT_W +: CNT_W] = period_q[t];
  end

  always_comb begin
    reg_rdata = '0;
    if (hi_hit) reg_rdata = DATA_W'(sel_hi);
    if (lo_hit) reg_rdata = DATA_W'(sel_lo);
    for (int t = 0; t < NUM_TIMERS; t++) begin
      if (per_hit[t]) reg_rdata = DATA_W'(period_q[t]);
    end
  end

  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !mapped) |=> ($stable(sel_hi) && $stable(sel_lo) && $stable(period_flat))) // R3
    else $error("unmapped write altered a register");
endmodule

// File: rtl/debounce_pool_pick.sv
module debounce_pool_pick
  import debounce_pool_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CODE_W-1:0]           code,
  input  logic [NUM_TIMERS*CNT_W-1:0] period_flat,
  output logic [CNT_W-1:0]            period
);
  always_comb begin
    period = '0;
    for (int t = 0; t < NUM_TIMERS; t++) begin
      if (code == CODE_W'(t + 1)) period = period_flat[t*CNT_W +: CNT_W];
    end
  end
endmodule

// File: rtl/debounce_pool_cell.sv
module debounce_pool_cell
  import debounce_pool_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw,
  input  logic [CODE_W-1:0] code,
  input  logic [CNT_W-1:0]  period,
  output logic              db
);
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W:0]    cnt_inc;
  logic              bypass, restart, reached;

  assign bypass  = (code == CODE_OFF) || (period == '0);
  assign restart = (code != code_q);
  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign reached = (cnt_inc >= {1'b0, period});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_OFF;
      cnt    <= '0;
      db     <= 1'b0;
    end else begin
      code_q <= code;
      if (bypass) begin
        db  <= raw;
        cnt <= '0;
      end else if (restart || (raw == db)) begin
        cnt <= '0;
      end else if (reached) begin
        db  <= raw;
        cnt <= '0;
      end else begin
        cnt <= cnt_inc[CNT_W-1:0];
      end
    end
  end

  AST_BYPASS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_OFF) |=> (db == $past(raw))) // R4
    else $error("code 0 pin did not track input");

  AST_ZERO_PERIOD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((code != CODE_OFF) && (period == '0)) |=> (db == $past(raw))) // R8
    else $error("zero period pin did not track input");

  AST_FLIP_TO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (db != $past(db)) |-> (db == $past(raw))) // R6
    else $error("output moved to a level the input did not have");

  AST_RESTART_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((code != code_q) && (code != CODE_OFF) && (period != '0)) |=> $stable(db)) // R9
    else $error("code change disturbed the output");
endmodule

// File: rtl/debounce_pool.sv
module debounce_pool
  import debounce_pool_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pin_raw,
  output logic [NUM_PINS-1:0] pin_db
);
  logic [NUM_PINS-1:0]         sel_hi, sel_lo;
  logic [NUM_TIMERS*CNT_W-1:0] period_flat;

  debounce_pool_regs #(
    .NUM_PINS(NUM_PINS), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .sel_hi     (sel_hi),
    .sel_lo     (sel_lo),
    .period_flat(period_flat)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  period;

    assign code = {sel_hi[i], sel_lo[i]};

    debounce_pool_pick #(.CNT_W(CNT_W)) u_pick (
      .code       (code),
      .period_flat(period_flat),
      .period     (period)
    );

    debounce_pool_cell #(.CNT_W(CNT_W)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (pin_raw[i]),
      .code  (code),
      .period(period),
      .db    (pin_db[i])
    );
  end
endmodule

// File: tb/debounce_pool_tb.sv
`timescale 1ns/1ps
module debounce_pool_tb;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] pin_raw = '0;
  logic [NP-1:0] pin_db;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  debounce_pool #(.NUM_PINS(NP), .CNT_W(16), .DATA_W(32), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_raw(pin_raw), .pin_db(pin_db)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  // Toggle one pin and count rising edges until its output follows.
  task automatic measure(input int pin, input int exp, input string req);
    logic start;
    int   got;
    start = pin_db[pin];
    pin_raw[pin] = ~start;
    got = 99;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (pin_db[pin] != start) begin
        got = k;
        break;
      end
    end
    chk(req, 32'(got), 32'(exp));
  endtask

  function automatic int per_of(input int round, input int t);
    return (round * 7 + t * 3 + 2) % 9;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk(8'h00, 32'h0, "R1 sel hi");
    rd_chk(8'h04, 32'h0, "R1 sel lo");
    rd_chk(8'h10, 32'h0, "R1 period1");
    rd_chk(8'h14, 32'h0, "R1 period2");
    rd_chk(8'h18, 32'h0, "R1 period3");
    chk("R1 outputs", 32'(pin_db), 32'h0);

    // R2 readback and truncation
    wr(8'h00, 32'hFFFF_FFA5);
    wr(8'h04, 32'h1234_5F3C);
    wr(8'h10, 32'hABCD_1234);
    wr(8'h14, 32'h0000_0007);
    wr(8'h18, 32'hFFFF_FFFF);
    rd_chk(8'h00, 32'hA5, "R2 sel hi");
    rd_chk(8'h04, 32'h3C, "R2 sel lo");
    rd_chk(8'h10, 32'h1234, "R2 period1");
    rd_chk(8'h14, 32'h7, "R2 period2");
    rd_chk(8'h18, 32'hFFFF, "R2 period3");

    // R3 unmapped addresses
    for (int a = 0; a < 64; a += 4) begin
      if (a != 'h00 && a != 'h04 && a != 'h10 && a != 'h14 && a != 'h18) begin
        wr(8'(a), 32'hFFFF_FFFF);
        rd_chk(8'(a), 32'h0, "R3 unmapped read");
      end
    end
    rd_chk(8'h00, 32'hA5, "R3 sel hi kept");
    rd_chk(8'h04, 32'h3C, "R3 sel lo kept");
    rd_chk(8'h10, 32'h1234, "R3 period1 kept");
    rd_chk(8'h14, 32'h7, "R3 period2 kept");
    rd_chk(8'h18, 32'hFFFF, "R3 period3 kept");

    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);
    repeat (2) @(negedge clk);

    // Sweep: every pin, every code, three period sets (R4 R5 R6 R8)
    for (int r = 0; r < 3; r++) begin
      for (int t = 0; t < 3; t++) wr(8'(16 + 4 * t), 32'(per_of(r, t)));
      for (int p = 0; p < NP; p++) begin
        for (int c = 0; c < 4; c++) begin
          int pe, ex;
          string tag;
          wr(8'h00, 32'((c >> 1) & 1) << p);
          wr(8'h04, 32'(c & 1) << p);
          repeat (2) @(negedge clk);
          pe = (c == 0) ? 0 : per_of(r, c - 1);
          ex = (pe == 0) ? 1 : pe;
          tag = (c == 0) ? "R4 code0" : ((pe == 0) ? "R8 zero period" : "R5 R6 filtered");
          measure(p, ex, {tag, " rise"});
          measure(p, ex, {tag, " fall"});
        end
      end
    end

    // R7 short excursion
    wr(8'h18, 32'd6);
    wr(8'h00, 32'h04);
    wr(8'h04, 32'h04);
    repeat (2) @(negedge clk);
    pin_raw[2] = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 before window end", 32'(pin_db[2]), 32'h0);
    pin_raw[2] = 1'b0;
    begin
      logic moved;
      moved = 1'b0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (pin_db[2]) moved = 1'b1;
      end
      chk("R7 glitch rejected", 32'(moved), 32'h0);
    end
    measure(2, 6, "R7 full window after glitch");
    measure(2, 6, "R7 full window fall");

    // R10 independent pins
    wr(8'h10, 32'd3);
    wr(8'h14, 32'd5);
    wr(8'h00, 32'h02);
    wr(8'h04, 32'h01);
    repeat (2) @(negedge clk);
    pin_raw[1:0] = 2'b11;
    repeat (2) @(negedge clk);
    chk("R10 both pending", 32'(pin_db[1:0]), 32'h0);
    @(negedge clk);
    chk("R10 pin0 at 3", 32'(pin_db[1:0]), 32'h1);
    repeat (2) @(negedge clk);
    chk("R10 pin1 at 5", 32'(pin_db[1:0]), 32'h3);
    pin_raw[1:0] = 2'b00;
    repeat (6) @(negedge clk);

    // R9 code change restarts count and holds output
    wr(8'h14, 32'd6);
    wr(8'h18, 32'd6);
    wr(8'h00, 32'h08);
    wr(8'h04, 32'h08);
    repeat (2) @(negedge clk);
    pin_raw[3] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 before change", 32'(pin_db[3]), 32'h0);
    wr(8'h04, 32'h00);
    repeat (6) @(negedge clk);
    chk("R9 restarted hold", 32'(pin_db[3]), 32'h0);
    @(negedge clk);
    chk("R9 settles after restart", 32'(pin_db[3]), 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule